// File: doc/BRIEF.md
# Destination Address Filter with Multicast Hash

This block sits at the front of an Ethernet receive path and decides, from the destination address alone, whether a frame is kept. The address arrives as a stream of bytes, first byte first, one byte on each cycle that `byte_vld` is high. A `sof` pulse marks the start of each frame. The block folds each byte into a CRC-32 as it arrives, one byte per cycle, and compares the byte with the station address. When the sixth byte has been consumed, it produces a one-cycle decision strobe. The accept result, the group flag and a receive status byte are then held until the next frame starts.

Three configuration bits control the filter. Promiscuous mode passes every frame. The all-ones broadcast address is gated by its own enable bit. Any other address whose first byte has bit 0 set is treated as multicast. It is gated by a multicast enable and then by one bit of a 64-bit hash table, selected by the top six bits of the CRC. All remaining addresses must equal the station address exactly.

Top module: `eth_dest_filter`

## Requirements
- R1: After reset, `dec_valid`, `accept`, `is_group` and `rx_status` are all 0.
- R2: `dec_valid` is high for exactly the one cycle that follows the clock edge on which the sixth address byte is taken. `accept`, `is_group` and `rx_status` change at that edge and then hold until the next `sof`. A `sof` without a byte clears all three outputs at its edge.
- R3: When `rx_cfg[4]` is 1, the frame is accepted whatever its address.
- R4: The address 48'hFFFFFFFFFFFF is broadcast. Unless promiscuous, it is accepted exactly when `rx_cfg[2]` is 1.
- R5: A non-broadcast address whose first byte has bit 0 set is multicast. Unless promiscuous, it is accepted only when `rx_cfg[3]` is 1 and the selected hash bit is 1.
- R6: The hash CRC starts at 32'hFFFFFFFF. Address bytes are taken in arrival order, each bit 0 first. For each bit, feedback = CRC[31] XOR the data bit, and the CRC shifts left by one. When the feedback is 1, the CRC is XORed with 32'h04C11DB6 and its bit 0 is set. The index is CRC[31:26], and it selects `hash_tbl[index]` (bit index mod 8 of table byte index div 8, byte k in bits 8k+7:8k).
- R7: Any other address is accepted, unless promiscuous, only when every byte k (k = 0 for the first received) equals `station_addr[8k+7:8k]`.
- R8: `rx_status` is 8'h21 for an accepted group (multicast or broadcast) address, 8'h01 for an accepted individual address, and 8'h00 when the frame is rejected. `is_group` is bit 0 of the first byte.
- R9: Cycles with `byte_vld` low are skipped without effect. Bytes after the sixth do not change the held decision.
- R10: A `sof` in the middle of a frame discards the partial address. The CRC, the byte count and the comparison state restart, so the following six bytes are judged on their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Start of frame; restarts filter state (a byte on the same cycle counts as the first) |
| byte_vld | input | 1 | `byte_in` carries an address byte |
| byte_in | input | 8 | Address byte |
| rx_cfg | input | 8 | Bit 2 broadcast enable, bit 3 multicast enable, bit 4 promiscuous |
| station_addr | input | 48 | Station address, first byte in bits 7:0 |
| hash_tbl | input | 64 | Multicast hash filter, bit n for index n |
| dec_valid | output | 1 | One-cycle decision strobe |
| accept | output | 1 | Frame accepted (held) |
| is_group | output | 1 | Destination is a group address (held) |
| rx_status | output | 8 | Receive status byte (held) |

## Verification
The frames are built so that each one separates a single pair of paths. Individual addresses that copy the station address are set against copies with one byte altered, which tells exact match from partial match. Multicast addresses are run against random hash tables, and also against tables holding only the computed bit or every bit except it, which pins down the CRC bit order and the index. The broadcast address is tried under every enable combination, so the broadcast enable is told apart from the multicast enable. Further runs insert idle gaps, send trailing bytes after the sixth, and restart with `sof` in the middle of an address, which checks that the decision depends only on the six bytes after the last restart.

// File: rtl/eth_dest_filter.sv
module eth_dest_filter #(
  parameter int          NBYTES = 6,
  parameter int          HBITS  = 6,
  parameter logic [31:0] POLY   = 32'h04C11DB6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sof,
  input  logic                  byte_vld,
  input  logic [7:0]            byte_in,
  input  logic [7:0]            rx_cfg,
  input  logic [8*NBYTES-1:0]   station_addr,
  input  logic [(1<<HBITS)-1:0] hash_tbl,
  output logic                  dec_valid,
  output logic                  accept,
  output logic                  is_group,
  output logic [7:0]            rx_status
);
  localparam int CW = $clog2(NBYTES + 1);

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = (r ^ POLY) | 32'd1;
    end
    return r;
  endfunction

  logic [CW-1:0] cnt_q, cnt_b;
  logic [31:0]   crc_q, crc_b, crc_n;
  logic          ones_q, ones_b, ones_n;
  logic          match_q, match_b, match_n;
  logic          grp_q, grp_b, grp_n;
  logic [7:0]    sta_byte;
  logic          take, last, hit, pass;

  assign cnt_b   = sof ? '0 : cnt_q;
  assign crc_b   = sof ? '1 : crc_q;
  assign ones_b  = sof | ones_q;
  assign match_b = sof | match_q;
  assign grp_b   = sof ? 1'b0 : grp_q;

  always_comb begin
    sta_byte = '0;
    for (int k = 0; k < NBYTES; k++)
      if (cnt_b == CW'(k)) sta_byte = station_addr[8*k +: 8];
  end

  assign take    = byte_vld && (cnt_b < CW'(NBYTES));
  assign last    = take && (cnt_b == CW'(NBYTES - 1));
  assign crc_n   = crc_step(crc_b, byte_in);
  assign ones_n  = ones_b & (&byte_in);
  assign match_n = match_b & (byte_in == sta_byte);
  assign grp_n   = (cnt_b == '0) ? byte_in[0] : grp_b;
  assign hit     = hash_tbl[crc_n[31 -: HBITS]];
  assign pass    = rx_cfg[4] | (ones_n ? rx_cfg[2] : grp_n ? (rx_cfg[3] & hit) : match_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      crc_q     <= '1;
      ones_q    <= 1'b1;
      match_q   <= 1'b1;
      grp_q     <= 1'b0;
      dec_valid <= 1'b0;
      accept    <= 1'b0;
      is_group  <= 1'b0;
    end else begin
      cnt_q     <= take ? cnt_b + CW'(1) : cnt_b;
      crc_q     <= take ? crc_n   : crc_b;
      ones_q    <= take ? ones_n  : ones_b;
      match_q   <= take ? match_n : match_b;
      grp_q     <= take ? grp_n   : grp_b;
      dec_valid <= last;
      if (last) begin
        accept   <= pass;
        is_group <= grp_n;
      end else if (sof) begin
        accept   <= 1'b0;
        is_group <= 1'b0;
      end
    end
  end

  assign rx_status = accept ? {2'b00, is_group, 4'b0000, 1'b1} : 8'h00;

  a_r2_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof && !byte_vld) |=> ($stable(accept) && $stable(is_group) && !dec_valid));
  a_r2_sof_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !byte_vld) |=> (!accept && !dec_valid && rx_status == 8'h00));
  a_r3_promisc_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (last && rx_cfg[4]) |=> (dec_valid && accept));
  a_r4_r5_group_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (last && rx_cfg[4:2] == 3'b000) |=> !(accept && is_group));
  a_r9_no_change_after: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof && cnt_q == CW'(NBYTES)) |=> $stable(accept));
endmodule

// File: tb/eth_dest_filter_tb.sv
`timescale 1ns/1ps
module eth_dest_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0, byte_vld = 1'b0;
  logic [7:0]  byte_in = '0, rx_cfg = '0;
  logic [47:0] station_addr = '0;
  logic [63:0] hash_tbl = '0;
  logic        dec_valid, accept, is_group;
  logic [7:0]  rx_status;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  eth_dest_filter u_dut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld), .byte_in(byte_in),
    .rx_cfg(rx_cfg), .station_addr(station_addr), .hash_tbl(hash_tbl),
    .dec_valid(dec_valid), .accept(accept), .is_group(is_group), .rx_status(rx_status));

  function automatic logic [5:0] hidx(input logic [47:0] f);
    logic [31:0] c = 32'hFFFFFFFF;
    logic b;
    for (int i = 0; i < 48; i++) begin
      b = c[31] ^ f[i];
      c = c << 1;
      if (b) c = (c ^ 32'h04C11DB6) | 32'h1;
    end
    return c[31:26];
  endfunction

  function automatic logic [7:0] model(input logic [47:0] f, input logic [7:0] cfg,
                                       input logic [47:0] sta, input logic [63:0] ht);
    bit grp = f[0];
    bit ok;
    if (cfg[4]) ok = 1;
    else if (f == '1) ok = cfg[2];
    else if (grp) ok = cfg[3] && ht[hidx(f)];
    else ok = (f == sta);
    return ok ? (grp ? 8'h21 : 8'h01) : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] f, input bit gaps, input bit trail, input string req);
    logic [7:0] e = model(f, rx_cfg, station_addr, hash_tbl);
    @(negedge clk); sof = 1; byte_vld = 0;
    @(negedge clk); sof = 0;
    chk(!accept && !dec_valid, "R2 cleared by sof", {accept, dec_valid}, 0);
    for (int k = 0; k < 6; k++) begin
      byte_vld = 1; byte_in = f[8*k +: 8];
      @(negedge clk);
      if (gaps && k < 5 && ($urandom % 3 == 0)) begin
        byte_vld = 0;
        @(negedge clk);
        chk(!dec_valid, "R9 idle gap", dec_valid, 0);
      end
    end
    byte_vld = 0;
    chk(dec_valid == 1, {req, " R2 strobe"}, dec_valid, 1);
    chk(rx_status == e, {req, " R8 status"}, rx_status, e);
    chk(accept == e[0] && is_group == f[0], {req, " accept/group"}, {accept, is_group}, {e[0], f[0]});
    if (trail) begin
      byte_vld = 1; byte_in = ~f[7:0];
      @(negedge clk);
      byte_in = 8'hFF;
      @(negedge clk);
      byte_vld = 0;
      chk(!dec_valid && rx_status == e, "R9 trailing bytes", {dec_valid, rx_status}, {1'b0, e});
    end else begin
      @(negedge clk);
      chk(!dec_valid && rx_status == e, "R2 hold", {dec_valid, rx_status}, {1'b0, e});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] f;
    logic [5:0]  ix;
    void'($urandom(32'd4242));
    station_addr = 48'h5634_1200_AB02;
    repeat (3) @(negedge clk);
    chk(!dec_valid && !accept && !is_group && rx_status == 0, "R1 reset", rx_status, 0);
    rst_n = 1;
    @(negedge clk);

    rx_cfg = 8'h00; send(station_addr, 0, 0, "R7 exact");
    send(station_addr ^ 48'h0100_0000_0000, 0, 0, "R7 last byte diff");
    rx_cfg = 8'h10; send(48'h1234_5678_9A02, 0, 0, "R3 promisc unicast");
    send('1, 0, 0, "R3 promisc bcast");
    rx_cfg = 8'h04; send('1, 0, 0, "R4 bcast on");
    rx_cfg = 8'h08; send('1, 0, 0, "R4 bcast off mcast on");
    rx_cfg = 8'h04; send(48'h0000_005E_0001, 0, 0, "R5 mcast disabled");
    f = 48'h0100_005E_0001; ix = hidx(f);
    rx_cfg = 8'h08; hash_tbl = 64'h1 << ix; send(f, 0, 0, "R6 single hash bit");
    hash_tbl = ~(64'h1 << ix); send(f, 0, 0, "R6 all but index");
    hash_tbl = '1; send(f, 1, 1, "R9 gaps and trail");

    // R10: partial frame then restart
    rx_cfg = 8'h00;
    @(negedge clk); sof = 1;
    @(negedge clk); sof = 0; byte_vld = 1; byte_in = 8'hFF;
    @(negedge clk); @(negedge clk); @(negedge clk); byte_vld = 0;
    send(station_addr, 0, 0, "R10 restart");

    for (int n = 0; n < 400; n++) begin
      station_addr = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFE;
      hash_tbl     = {$urandom, $urandom};
      rx_cfg       = 8'($urandom) & 8'h1C;
      case ($urandom % 4)
        0: f = station_addr;
        1: f = station_addr ^ (48'h1 << (1 + $urandom % 47));
        2: f = {$urandom, $urandom} | 48'h1;
        default: f = '1;
      endcase
      send(f, $urandom % 2, $urandom % 2, "R5 R6 R7 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule